// File: doc/BRIEF.md
# Lockable Memory Window Base Register

This block holds one 64-bit configuration register. The register places a 32 KB memory-mapped window anywhere in a 39-bit physical address space and has a single enable bit. Software programs it through a byte-enabled configuration write port and reads it back through a read-data output that always reflects the current contents. A hardware lock input freezes the whole register. While the lock is high, configuration writes are discarded and the base and the enable keep their values.

A request side carries a valid strobe and an address. A decoder compares each valid address with the programmed base and raises a claim output one cycle later. The claim goes high only when the window is enabled and the address lies inside the naturally aligned 32 KB block. Any address that reaches past the 512 GB physical limit is refused. The window size, the physical address width and the request address width are parameters; the defaults give the layout described here.

Top module: `winbase_reg`

## Requirements
- R1: Synchronous reset clears the register, so `cfg_rdata` reads 64'h0, and holds `hit` low.
- R2: Register bits 38:15 are read/write and hold window base address bits 38:15.
- R3: Bits 63:39 and 14:1 always read as zero. A write that sets them leaves them zero.
- R4: Bit 0 is the enable. While it is 0, no request is claimed, even when the address matches the base.
- R5: A valid request whose bits 38:15 equal the stored base is claimed when the enable is 1. This holds for every offset 0 through 7FFFh inside the window. Addresses one below the window or 8000h above its base are not claimed.
- R6: A request address with any bit at position 39 or above set is never claimed.
- R7: Writes are byte-enabled. `cfg_be[i]` guards bits 8i+7:8i. With `cfg_be`=8'h0F only the lower 32 bits can change, and with 8'hF0 only the upper 32 bits can change.
- R8: While `cfg_lock` is 1, configuration writes have no effect on either the base or the enable.
- R9: `cfg_rdata` returns the stored value, with reserved bits zero, whether or not the lock is asserted.
- R10: `hit` is a registered output. It is high in the cycle after a qualifying request and low after any cycle with `req_valid` low.
- R11: A request in the same cycle as an accepted write that changes the base or the enable is not claimed. A write that leaves the value unchanged does not block the claim.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_be | input | 8 | Byte enables for the write, one per byte lane |
| cfg_wdata | input | 64 | Configuration write data |
| cfg_lock | input | 1 | Freezes the register while high |
| cfg_rdata | output | 64 | Current register value, reserved bits zero |
| req_valid | input | 1 | Request address strobe |
| req_addr | input | 64 | Request address |
| hit | output | 1 | Window claim, one cycle after the request |

## Verification
The hardest situation to reach is a request that lands in the same cycle as a configuration write. Depending on whether that write really alters the stored value, the claim must be suppressed or kept. The stimulus reaches both cases. It issues a matching request together with a write that moves the base. It then issues a request together with a write that rewrites the current value, and one together with a write blocked by the lock. The expected claim for each request is computed from a bench-side model of the register, taken before the write, and queued for comparison one cycle later.

// File: rtl/winbase_pkg.sv
package winbase_pkg;

   localparam int unsigned REG_BYTES = 8;
   localparam int unsigned REG_W     = REG_BYTES * 8;

   typedef struct packed {
      logic                 we;
      logic [REG_BYTES-1:0] be;
      logic [REG_W-1:0]     data;
   } cfg_wr_t;

   // Bits that hold state: the base field and the enable bit.
   function automatic logic [REG_W-1:0] writable_mask(int unsigned phys_w,
                                                      int unsigned win_log2);
      logic [REG_W-1:0] m;
      m = '0;
      for (int unsigned i = 0; i < REG_W; i++) begin
         if (i >= win_log2 && i < phys_w) m[i] = 1'b1;
      end
      m[0] = 1'b1;
      return m;
   endfunction

endpackage

// File: rtl/winbase_store.sv
module winbase_store
   import winbase_pkg::*;
#(
   parameter int unsigned PHYS_W   = 39,
   parameter int unsigned WIN_LOG2 = 15,
   localparam int unsigned BASE_W  = PHYS_W - WIN_LOG2
) (
   input  logic              clk,
   input  logic              rst,
   input  cfg_wr_t           wr,
   input  logic              lock,
   output logic [BASE_W-1:0] base,
   output logic              en,
   output logic [REG_W-1:0]  rd_val,
   output logic              upd
);

   localparam logic [REG_W-1:0] WMASK = writable_mask(PHYS_W, WIN_LOG2);

   logic [REG_W-1:0] lane_mask;
   logic [REG_W-1:0] nxt;
   logic             wr_ok;

   // One mask slice per byte lane.
   for (genvar g = 0; g < REG_BYTES; g++) begin : g_lane
      assign lane_mask[g*8 +: 8] = {8{wr.be[g]}};
   end

   always_comb begin
      rd_val                      = '0;
      rd_val[PHYS_W-1:WIN_LOG2]   = base;
      rd_val[0]                   = en;
   end

   assign nxt   = (rd_val & ~(lane_mask & WMASK)) | (wr.data & lane_mask & WMASK);
   assign wr_ok = wr.we & ~lock;
   assign upd   = wr_ok & (nxt != rd_val);

   always_ff @(posedge clk) begin
      if (rst) begin
         base <= '0;
         en   <= 1'b0;
      end else if (wr_ok) begin
         base <= nxt[PHYS_W-1:WIN_LOG2];
         en   <= nxt[0];
      end
   end

endmodule

// File: rtl/winbase_decode.sv
module winbase_decode #(
   parameter int unsigned PHYS_W     = 39,
   parameter int unsigned WIN_LOG2   = 15,
   parameter int unsigned REQ_ADDR_W = 64,
   localparam int unsigned BASE_W    = PHYS_W - WIN_LOG2
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  req_valid,
   input  logic [REQ_ADDR_W-1:0] req_addr,
   input  logic [BASE_W-1:0]     base,
   input  logic                  en,
   input  logic                  blocked,
   output logic                  hit
);

   logic high_zero;
   logic base_eq;
   logic unused_offset;

   // Upper-bit range check only exists when the request bus is wider.
   if (REQ_ADDR_W > PHYS_W) begin : g_wide
      assign high_zero = ~|req_addr[REQ_ADDR_W-1:PHYS_W];
   end else begin : g_exact
      assign high_zero = 1'b1;
   end

   assign base_eq       = (req_addr[PHYS_W-1:WIN_LOG2] == base);
   assign unused_offset = ^req_addr[WIN_LOG2-1:0];

   always_ff @(posedge clk) begin
      if (rst) hit <= 1'b0;
      else     hit <= req_valid & high_zero & base_eq & en & ~blocked;
   end

endmodule

// File: rtl/winbase_reg.sv
module winbase_reg
   import winbase_pkg::*;
#(
   parameter int unsigned PHYS_W     = 39,
   parameter int unsigned WIN_LOG2   = 15,
   parameter int unsigned REQ_ADDR_W = 64
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  cfg_we,
   input  logic [REG_BYTES-1:0]  cfg_be,
   input  logic [REG_W-1:0]      cfg_wdata,
   input  logic                  cfg_lock,
   output logic [REG_W-1:0]      cfg_rdata,
   input  logic                  req_valid,
   input  logic [REQ_ADDR_W-1:0] req_addr,
   output logic                  hit
);

   localparam int unsigned BASE_W = PHYS_W - WIN_LOG2;

   if (WIN_LOG2 < 1 || WIN_LOG2 >= PHYS_W) begin : g_bad_win
      $error("window size must be smaller than the physical space");
   end
   if (PHYS_W > REG_W) begin : g_bad_phys
      $error("physical width exceeds register width");
   end
   if (REQ_ADDR_W < PHYS_W) begin : g_bad_req
      $error("request address narrower than physical width");
   end

   cfg_wr_t           wr;
   logic [BASE_W-1:0] base;
   logic              en;
   logic              upd;

   assign wr = '{we: cfg_we, be: cfg_be, data: cfg_wdata};

   winbase_store #(.PHYS_W(PHYS_W), .WIN_LOG2(WIN_LOG2)) u_store (
      .clk    (clk),
      .rst    (rst),
      .wr     (wr),
      .lock   (cfg_lock),
      .base   (base),
      .en     (en),
      .rd_val (cfg_rdata),
      .upd    (upd)
   );

   winbase_decode #(.PHYS_W(PHYS_W), .WIN_LOG2(WIN_LOG2), .REQ_ADDR_W(REQ_ADDR_W)) u_decode (
      .clk       (clk),
      .rst       (rst),
      .req_valid (req_valid),
      .req_addr  (req_addr),
      .base      (base),
      .en        (en),
      .blocked   (upd),
      .hit       (hit)
   );

endmodule

// File: rtl/winbase_chk.sv
module winbase_chk #(
   parameter int unsigned PHYS_W     = 39,
   parameter int unsigned WIN_LOG2   = 15,
   parameter int unsigned REQ_ADDR_W = 64
) (
   input logic                  clk,
   input logic                  rst,
   input logic                  cfg_we,
   input logic                  cfg_lock,
   input logic [63:0]           cfg_rdata,
   input logic                  req_valid,
   input logic [REQ_ADDR_W-1:0] req_addr,
   input logic                  hit
);

   logic high_set;
   if (REQ_ADDR_W > PHYS_W) begin : g_hs
      assign high_set = |req_addr[REQ_ADDR_W-1:PHYS_W];
   end else begin : g_nohs
      assign high_set = 1'b0;
   end

   p_reset_clear_r1: assert property (@(posedge clk) $past(rst) |-> (cfg_rdata == 64'h0 && !hit));

   p_resv_zero_r3: assert property (@(posedge clk) disable iff (rst)
      (cfg_rdata[63:PHYS_W] == '0 && cfg_rdata[WIN_LOG2-1:1] == '0));

   p_disabled_no_hit_r4: assert property (@(posedge clk) disable iff (rst)
      hit |-> $past(cfg_rdata[0]));

   p_upper_miss_r6: assert property (@(posedge clk) disable iff (rst)
      (req_valid && high_set) |=> !hit);

   p_lock_freeze_r8: assert property (@(posedge clk) disable iff (rst)
      (cfg_lock && cfg_we) |=> $stable(cfg_rdata));

   p_hit_needs_valid_r10: assert property (@(posedge clk) disable iff (rst)
      !req_valid |=> !hit);

   p_change_blocks_hit_r11: assert property (@(posedge clk) disable iff (rst)
      hit |-> $stable(cfg_rdata));

endmodule

bind winbase_reg winbase_chk #(
   .PHYS_W(PHYS_W), .WIN_LOG2(WIN_LOG2), .REQ_ADDR_W(REQ_ADDR_W)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .cfg_we    (cfg_we),
   .cfg_lock  (cfg_lock),
   .cfg_rdata (cfg_rdata),
   .req_valid (req_valid),
   .req_addr  (req_addr),
   .hit       (hit)
);

// File: tb/winbase_reg_bench.sv
module winbase_reg_bench;

   localparam logic [63:0] WM = 64'h0000_007F_FFFF_8001;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        cfg_we = 1'b0;
   logic [7:0]  cfg_be = 8'h00;
   logic [63:0] cfg_wdata = 64'h0;
   logic        cfg_lock = 1'b0;
   logic [63:0] cfg_rdata;
   logic        req_valid = 1'b0;
   logic [63:0] req_addr = 64'h0;
   logic        hit;

   always #10 clk = ~clk;

   winbase_reg u_winbase_reg (
      .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
      .cfg_lock(cfg_lock), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
      .req_addr(req_addr), .hit(hit)
   );

   typedef struct {
      int    due;
      logic  exp;
      string tag;
   } item_t;

   item_t       sb[$];
   int          cyc = 0;
   int          n_vec = 0;
   int          n_bad = 0;
   logic [63:0] m_reg = 64'h0;
   bit          done = 0;

   always @(posedge clk) cyc <= cyc + 1;

   // Monitor: compare hit against queued expectations when due.
   always @(negedge clk) begin
      if (sb.size() > 0 && sb[0].due == cyc) begin
         item_t it;
         it = sb.pop_front();
         n_vec++;
         if (hit !== it.exp) begin
            n_bad++;
            $display("FAIL %s: hit actual=%b expected=%b", it.tag, hit, it.exp);
         end
      end
   end

   function automatic logic [63:0] merge(logic [63:0] cur, logic [7:0] be, logic [63:0] d);
      logic [63:0] lm;
      for (int i = 0; i < 8; i++) lm[i*8 +: 8] = {8{be[i]}};
      return (cur & ~(lm & WM)) | (d & lm & WM);
   endfunction

   // Driver: one cycle of stimulus, expected hit pushed to the scoreboard.
   task automatic cycle(input logic v, input logic [63:0] a, input logic we,
                        input logic [7:0] be, input logic [63:0] d, input string tag);
      logic [63:0] nv;
      logic        chg;
      item_t       it;
      @(negedge clk);
      req_valid = v; req_addr = a; cfg_we = we; cfg_be = be; cfg_wdata = d;
      nv  = (we && !cfg_lock) ? merge(m_reg, be, d) : m_reg;
      chg = (nv != m_reg);
      it.due = cyc + 1;
      it.exp = v && (a[63:39] == 25'h0) && (a[38:15] == m_reg[38:15]) && m_reg[0] && !chg;
      it.tag = tag;
      sb.push_back(it);
      @(posedge clk);
      m_reg = nv;
   endtask

   task automatic req(input logic [63:0] a, input string tag);
      cycle(1'b1, a, 1'b0, 8'h00, 64'h0, tag);
   endtask

   task automatic wr(input logic [7:0] be, input logic [63:0] d, input string tag);
      cycle(1'b0, 64'h0, 1'b1, be, d, tag);
   endtask

   task automatic chk_rd(input string tag);
      @(negedge clk);
      req_valid = 1'b0; cfg_we = 1'b0;
      n_vec++;
      if (cfg_rdata !== m_reg) begin
         n_bad++;
         $display("FAIL %s: rdata actual=%h expected=%h", tag, cfg_rdata, m_reg);
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_bad++;
         $display("FAIL R10 watchdog: actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      logic [63:0] b;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      // R1: reset state
      n_vec++;
      if (cfg_rdata !== 64'h0 || hit !== 1'b0) begin
         n_bad++;
         $display("FAIL R1: rdata/hit actual=%h/%b expected=0/0", cfg_rdata, hit);
      end
      // R4: matching base 0 but disabled
      req(64'h0, "R4 disabled");
      req(64'h7FFF, "R4 disabled top");
      // R3: all-ones write, reserved stay zero
      wr(8'hFF, 64'hFFFF_FFFF_FFFF_FFFF, "R3 write");
      chk_rd("R3 reserved zero");
      // R2: program base pattern with enable
      b = 64'h0000_0012_3456_8000;
      wr(8'hFF, b | 64'h1, "R2 write");
      chk_rd("R2 base readback");
      // R5: inside and outside window
      req(b, "R5 low edge");
      req(b | 64'h7FFF, "R5 high edge");
      req(b | 64'h1234, "R5 middle");
      req(b + 64'h8000, "R5 above");
      req(b - 64'h1, "R5 below");
      // R6: high bits set
      req(b | (64'h1 << 39), "R6 bit39");
      req(b | (64'h1 << 63), "R6 bit63");
      // R10: valid low
      cycle(1'b0, b, 1'b0, 8'h00, 64'h0, "R10 no valid");
      // R7: lower dword only
      wr(8'h0F, 64'hAAAA_AAAA_FFFF_8001, "R7 low write");
      chk_rd("R7 low half");
      wr(8'hF0, 64'h0000_0055_0000_0000, "R7 high write");
      chk_rd("R7 high half");
      req(m_reg & 64'h0000_007F_FFFF_8000, "R5 new base");
      // R11: changing write in same cycle blocks hit
      b = m_reg & 64'h0000_007F_FFFF_8000;
      cycle(1'b1, b, 1'b1, 8'hFF, 64'h0000_0001_0000_8001, "R11 changing write");
      req(64'h0000_0001_0000_8010, "R11 after change");
      cycle(1'b1, 64'h0000_0001_0000_8020, 1'b1, 8'hFF, 64'h0000_0001_0000_8001,
            "R11 same-value write");
      // R8/R9: lock freezes base and enable
      cfg_lock = 1'b1;
      cycle(1'b1, 64'h0000_0001_0000_8000, 1'b1, 8'hFF, 64'h0, "R8 locked write");
      chk_rd("R9 locked read");
      wr(8'h01, 64'h0, "R8 locked disable");
      chk_rd("R8 enable held");
      req(64'h0000_0001_0000_FFFF, "R8 still claims");
      cfg_lock = 1'b0;
      // R4: clear enable, matching address misses
      wr(8'h01, 64'h0, "R4 disable");
      chk_rd("R4 readback");
      req(64'h0000_0001_0000_8000, "R4 disabled match");
      // Drain
      cycle(1'b0, 64'h0, 1'b0, 8'h00, 64'h0, "R10 drain");
      repeat (3) @(negedge clk);
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule